// File: doc/BRIEF.md
# Platform I/O Test Peripheral

This block is a small peripheral that sits on a simple I/O bus and gives platform tests something to poke at. A bus access carries an address, a write strobe, a read strobe, write data and a byte count of 1, 2 or 4. The block holds one 32-bit scratch word that can be reached through two separate 4-byte windows. Writes merge the supplied bytes into the lanes chosen by the low address bits. Reads pull the addressed lanes down to bit 0.

A third window drives a bank of interrupt output lines. Each byte offset in that window owns one line, and a single-byte write sets the line high or low depending on whether the written byte is nonzero. A fourth window takes only full-word writes and discards them. An access whose byte count a window does not allow, or whose lanes would run past the end of a 4-byte window, is dropped. Such an access leaves all state as it was and raises a one-cycle error pulse. Read data and the error pulse both appear in the cycle after the access.

Top module: `tdev_io_top`

## Requirements
- R1: While rst_ni is low and after its release, the scratch word is zero, all irq_o lines are low, and rdata_o and err_o are zero.
- R2: size_i gives the byte count and only 1, 2 and 4 are legal. A legal write at scratch window offset o = addr_i mod 4 with o + size_i <= 4 replaces bytes o .. o+size_i-1 of the scratch word with wdata_i bytes 0 .. size_i-1, lowest address at bits 7:0. All other bytes are kept.
- R3: A legal read returns the scratch word shifted right by 8*o with only size_i bytes kept and upper bits zero. It is presented on rdata_o one cycle after rd_i. In any cycle not following an accepted read, rdata_o is zero.
- R4: The windows at 0x00E0..0x00E3 and 0x00E8..0x00EB reach the same scratch word with identical effect.
- R5: In a scratch window, an illegal size_i (0, 3, 5, 6 or 7) or o + size_i > 4 gives err_o = 1 for one cycle. Such a write leaves the word unchanged, and such a read returns zero.
- R6: A size-1 write to 0x2000+n, n < 24, sets irq_o[n] to (wdata_i[7:0] != 0) on the next cycle. Every other line keeps its value.
- R7: Any access to the interrupt window with size_i != 1 raises err_o and changes no line. Reads of that window return zero.
- R8: The window at 0x00E4..0x00E7 accepts only size 4 at 0x00E4, with no effect and zero read data. Any other size or offset there raises err_o.
- R9: An access to an unmapped address, including 0x2018 and above, returns zero, raises no error and changes no state.
- R10: err_o is registered: it is high exactly in the cycle after each rejected access and low otherwise.
- R11: When wr_i and rd_i are both high, only the write is performed and rdata_o stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | I/O byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| size_i | input | 3 | Access byte count |
| wdata_i | input | 32 | Write data, lane 0 at bits 7:0 |
| rdata_o | output | 32 | Read data, one cycle after rd_i |
| err_o | output | 1 | One-cycle rejected-access pulse |
| irq_o | output | 24 | Interrupt output lines |

## Verification
Some properties are checked by assertions on every cycle. A rejected access leaves the scratch word and the interrupt lines unchanged. The scratch word changes only under a write enable. At most one interrupt line moves per cycle, and only after a write. The read data bus is zero after any cycle that had no read.

Other results can only be shown by the bench scenarios. These are the lane merge for every offset and size in both windows, the extracted read values, the nonzero test on the low byte, and the rejection of each illegal size. The bench also covers the sink window, unmapped addresses beside every window, and a write and read issued in the same cycle.

// File: rtl/tdev_pkg.sv
package tdev_pkg;
  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_SCR_A,
    WIN_SINK,
    WIN_SCR_B,
    WIN_IRQ
  } win_e;

  typedef struct packed {
    win_e win;
    logic size_ok;
  } dec_t;
endpackage

// File: rtl/tdev_decode.sv
module tdev_decode
  import tdev_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LANES      = 4,
  parameter int NUM_IRQ    = 24,
  parameter int SCR_A_BASE = 'h00E0,
  parameter int SINK_BASE  = 'h00E4,
  parameter int SCR_B_BASE = 'h00E8,
  parameter int IRQ_BASE   = 'h2000,
  localparam int OFF_W     = $clog2(LANES),
  localparam int SIZE_W    = OFF_W + 1,
  localparam int IDX_W     = $clog2(NUM_IRQ)
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output dec_t              dec_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] A_B   = ADDR_W'(SCR_A_BASE);
  localparam logic [ADDR_W-1:0] S_B   = ADDR_W'(SINK_BASE);
  localparam logic [ADDR_W-1:0] B_B   = ADDR_W'(SCR_B_BASE);
  localparam logic [ADDR_W-1:0] I_B   = ADDR_W'(IRQ_BASE);
  localparam logic [ADDR_W-1:0] W_LEN = ADDR_W'(LANES);
  localparam logic [ADDR_W-1:0] I_LEN = ADDR_W'(NUM_IRQ);

  logic [ADDR_W-1:0] rel_a, rel_s, rel_b, rel_i;
  logic              pow2_ok, fit_a, fit_b;

  always_comb begin
    rel_a   = addr_i - A_B;
    rel_s   = addr_i - S_B;
    rel_b   = addr_i - B_B;
    rel_i   = addr_i - I_B;
    pow2_ok = (size_i != '0) && ((size_i & (size_i - 1'b1)) == '0)
              && (int'(size_i) <= LANES);
    fit_a   = (int'(rel_a[OFF_W-1:0]) + int'(size_i)) <= LANES;
    fit_b   = (int'(rel_b[OFF_W-1:0]) + int'(size_i)) <= LANES;
  end

  always_comb begin
    dec_o = '{win: WIN_NONE, size_ok: 1'b0};
    off_o = '0;
    idx_o = '0;
    if (rel_a < W_LEN) begin
      dec_o.win     = WIN_SCR_A;
      dec_o.size_ok = pow2_ok && fit_a;
      off_o         = rel_a[OFF_W-1:0];
    end else if (rel_s < W_LEN) begin
      dec_o.win     = WIN_SINK;
      dec_o.size_ok = (int'(size_i) == LANES) && (rel_s == '0);
    end else if (rel_b < W_LEN) begin
      dec_o.win     = WIN_SCR_B;
      dec_o.size_ok = pow2_ok && fit_b;
      off_o         = rel_b[OFF_W-1:0];
    end else if (rel_i < I_LEN) begin
      dec_o.win     = WIN_IRQ;
      dec_o.size_ok = (size_i == SIZE_W'(1));
      idx_o         = rel_i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/tdev_scratch.sv
module tdev_scratch #(
  parameter int LANES   = 4,
  localparam int OFF_W  = $clog2(LANES),
  localparam int SIZE_W = OFF_W + 1,
  localparam int DATA_W = LANES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0]       byte_q;
    logic [OFF_W-1:0] src;
    logic             hit;
    always_comb begin
      src = OFF_W'(l) - off_i;
      hit = (l >= int'(off_i)) && (int'(src) < int'(size_i));
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         byte_q <= '0;
      else if (we_i && hit) byte_q <= wdata_i[{src, 3'b000} +: 8];
    end
    assign q[l*8 +: 8] = byte_q;
  end

  // read: addressed lanes shifted to bit 0
  for (genvar k = 0; k < LANES; k++) begin : g_rd
    logic [OFF_W-1:0] sel;
    logic             use_lane;
    always_comb begin
      sel      = OFF_W'(k) + off_i;
      use_lane = (k < int'(size_i)) && ((k + int'(off_i)) < LANES);
    end
    assign rdata_o[k*8 +: 8] = use_lane ? q[{sel, 3'b000} +: 8] : 8'h00;
  end

  assign q_o = q;

  assert_hold_without_we_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q));
endmodule

// File: rtl/tdev_irq_bank.sv
module tdev_irq_bank #(
  parameter int NUM_IRQ = 24,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               level_i,
  output logic [NUM_IRQ-1:0] irq_o
);
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
    logic line_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                line_q <= 1'b0;
      else if (we_i && (idx_i == IDX_W'(n)))      line_q <= level_i;
    end
    assign irq_o[n] = line_q;
  end

  assert_one_line_moves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o ^ $past(irq_o)));
  assert_change_needs_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != $past(irq_o)) |-> $past(we_i));
endmodule

// File: rtl/tdev_io_top.sv
module tdev_io_top
  import tdev_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LANES      = 4,
  parameter int NUM_IRQ    = 24,
  parameter int SCR_A_BASE = 'h00E0,
  parameter int SINK_BASE  = 'h00E4,
  parameter int SCR_B_BASE = 'h00E8,
  parameter int IRQ_BASE   = 'h2000,
  localparam int OFF_W     = $clog2(LANES),
  localparam int SIZE_W    = OFF_W + 1,
  localparam int DATA_W    = LANES * 8,
  localparam int IDX_W     = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               err_o,
  output logic [NUM_IRQ-1:0] irq_o
);
  dec_t              dec;
  logic [OFF_W-1:0]  off;
  logic [IDX_W-1:0]  idx;
  logic              is_scr, rd_eff, err_d, scr_we, irq_we;
  logic [DATA_W-1:0] scr_rdata, scr_q, rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  tdev_decode #(
    .ADDR_W(ADDR_W), .LANES(LANES), .NUM_IRQ(NUM_IRQ),
    .SCR_A_BASE(SCR_A_BASE), .SINK_BASE(SINK_BASE),
    .SCR_B_BASE(SCR_B_BASE), .IRQ_BASE(IRQ_BASE)
  ) u_decode (
    .addr_i(addr_i), .size_i(size_i), .dec_o(dec), .off_o(off), .idx_o(idx)
  );

  always_comb begin
    is_scr  = (dec.win == WIN_SCR_A) || (dec.win == WIN_SCR_B);
    rd_eff  = rd_i && !wr_i;                      // write wins on collision
    err_d   = (wr_i || rd_i) && (dec.win != WIN_NONE) && !dec.size_ok;
    scr_we  = wr_i && is_scr && dec.size_ok;
    irq_we  = wr_i && (dec.win == WIN_IRQ) && dec.size_ok;
    rdata_d = (rd_eff && is_scr && dec.size_ok) ? scr_rdata : '0;
  end

  tdev_scratch #(.LANES(LANES)) u_scratch (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(scr_we), .off_i(off),
    .size_i(size_i), .wdata_i(wdata_i), .rdata_o(scr_rdata), .q_o(scr_q)
  );

  tdev_irq_bank #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(irq_we), .idx_i(idx),
    .level_i(wdata_i[7:0] != 8'h00), .irq_o(irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  assert_err_keeps_scratch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(scr_q));
  assert_err_keeps_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(irq_o));
  assert_rdata_idle_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_eff) |-> (rdata_o == '0));
  assert_collision_no_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && rd_i) |-> (rdata_o == '0));
endmodule

// File: tb/tdev_io_top_tb_top.sv
`timescale 1ns/1ps
module tdev_io_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [2:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [23:0] irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tdev_io_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit w, input bit r, input logic [15:0] a,
                     input logic [2:0] s, input logic [31:0] d,
                     output logic [31:0] rv, output logic ev);
    @(negedge clk);
    wr = w; rd = r; addr = a; size = s; wdata = d;
    @(negedge clk);
    rv = rdata; ev = err;
    wr = 1'b0; rd = 1'b0; addr = '0; size = '0; wdata = '0;
  endtask

  function automatic bit legal(int off, int s);
    return (s == 1 || s == 2 || s == 4) && (off + s <= 4);
  endfunction

  function automatic logic [31:0] lmask(int off, int s);
    logic [63:0] m;
    m = ((64'd1 << (s * 8)) - 64'd1) << (off * 8);
    return m[31:0];
  endfunction

  logic [31:0] model;
  logic [23:0] irq_m;
  logic [31:0] seed;
  logic [31:0] rv;
  logic        ev;

  task automatic read_word(input string req);
    acc(1'b0, 1'b1, 16'h00E0, 3'd4, 32'h0, rv, ev);
    chk(rv == model && !ev, req, rv, model);
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model = '0; irq_m = '0; seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R1 reset state while held
    chk(rdata == 0 && err == 0, "R1 rdata/err in reset", {rdata[30:0], err}, 0);
    chk(irq == 0, "R1 irq in reset", {8'h0, irq}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    read_word("R1 scratch after reset");

    // R2 R4 R5: sweep windows, offsets, sizes for writes
    for (int w = 0; w < 2; w++) begin
      for (int off = 0; off < 4; off++) begin
        for (int s = 0; s < 8; s++) begin
          logic [15:0] a;
          logic [31:0] m, sh;
          a = (w == 0 ? 16'h00E0 : 16'h00E8) + 16'(off);
          seed = seed * 32'd1103515245 + 32'd12345;
          acc(1'b1, 1'b0, a, 3'(s), seed, rv, ev);
          if (legal(off, s)) begin
            m = lmask(off, s);
            sh = seed << (off * 8);
            model = (model & ~m) | (sh & m);
            chk(ev == 1'b0, w == 0 ? "R2 legal write no err" : "R4 legal write no err",
                {31'h0, ev}, 0);
          end else begin
            chk(ev == 1'b1, "R5 illegal write err", {31'h0, ev}, 1);
          end
          read_word(w == 0 ? "R2 merged word" : "R4 alias merged word");
        end
      end
    end

    // R3 R4 R5: read sweep
    model = 32'hA1B2_C3D4;
    acc(1'b1, 1'b0, 16'h00E8, 3'd4, model, rv, ev);
    for (int w = 0; w < 2; w++) begin
      for (int off = 0; off < 4; off++) begin
        for (int s = 0; s < 8; s++) begin
          logic [15:0] a;
          logic [31:0] e;
          a = (w == 0 ? 16'h00E0 : 16'h00E8) + 16'(off);
          acc(1'b0, 1'b1, a, 3'(s), 32'h0, rv, ev);
          e = legal(off, s) ? ((model & lmask(off, s)) >> (off * 8)) : 32'h0;
          chk(rv == e, w == 0 ? "R3 read extract" : "R4 alias read", rv, e);
          chk(ev == !legal(off, s), "R5 read err", {31'h0, ev}, {31'h0, !legal(off, s)});
        end
      end
    end
    // R10 pulse ends after one rejected access
    acc(1'b0, 1'b1, 16'h00E3, 3'd2, 32'h0, rv, ev);
    @(negedge clk);
    chk(err == 1'b0, "R10 err one cycle", {31'h0, err}, 0);

    // R8 sink window
    for (int off = 0; off < 4; off++) begin
      for (int s = 0; s < 8; s++) begin
        bit ok;
        ok = (off == 0 && s == 4);
        acc(1'b1, 1'b0, 16'h00E4 + 16'(off), 3'(s), 32'hFFFF_FFFF, rv, ev);
        chk(ev == !ok, "R8 sink write err", {31'h0, ev}, {31'h0, !ok});
        acc(1'b0, 1'b1, 16'h00E4 + 16'(off), 3'(s), 32'h0, rv, ev);
        chk(rv == 0 && ev == !ok, "R8 sink read", rv, 0);
      end
    end
    read_word("R8 sink leaves scratch");
    chk(irq == 0, "R8 sink leaves irq", {8'h0, irq}, 0);

    // R6 irq lines
    for (int n = 0; n < 24; n++) begin
      acc(1'b1, 1'b0, 16'h2000 + 16'(n), 3'd1, 32'(n + 1), rv, ev);
      irq_m[n] = 1'b1;
      chk(irq == irq_m && !ev, "R6 irq set", {8'h0, irq}, {8'h0, irq_m});
    end
    for (int n = 0; n < 24; n += 3) begin
      acc(1'b1, 1'b0, 16'h2000 + 16'(n), 3'd1, 32'hFFFF_FF00, rv, ev);
      irq_m[n] = 1'b0;
      chk(irq == irq_m, "R6 irq clear on low byte zero", {8'h0, irq}, {8'h0, irq_m});
    end
    // R7 bad sizes and reads
    for (int s = 0; s < 8; s++) begin
      if (s != 1) begin
        acc(1'b1, 1'b0, 16'h2001, 3'(s), 32'h0, rv, ev);
        chk(ev && irq == irq_m, "R7 irq bad size", {8'h0, irq}, {8'h0, irq_m});
      end
    end
    acc(1'b0, 1'b1, 16'h2001, 3'd1, 32'h0, rv, ev);
    chk(rv == 0 && !ev, "R7 irq read zero", rv, 0);

    // R9 unmapped
    for (int i = 0; i < 8; i++) begin
      logic [15:0] a;
      a = 16'h2018 + 16'(i);
      acc(1'b1, 1'b0, a, 3'd1, 32'h0, rv, ev);
      chk(!ev && irq == irq_m, "R9 unmapped irq range", {8'h0, irq}, {8'h0, irq_m});
    end
    foreach (seed[i]) begin
      if (i < 6) begin
        logic [15:0] a;
        case (i)
          0: a = 16'h0000; 1: a = 16'h00DF; 2: a = 16'h00EC;
          3: a = 16'h1FFF; 4: a = 16'h2018; default: a = 16'hFFFF;
        endcase
        acc(1'b1, 1'b0, a, 3'd4, 32'hDEAD_BEEF, rv, ev);
        chk(!ev, "R9 unmapped write no err", {31'h0, ev}, 0);
        acc(1'b0, 1'b1, a, 3'd4, 32'h0, rv, ev);
        chk(rv == 0 && !ev, "R9 unmapped read zero", rv, 0);
      end
    end
    read_word("R9 scratch untouched");

    // R11 collision
    acc(1'b1, 1'b1, 16'h00E0, 3'd4, 32'h5566_7788, rv, ev);
    model = 32'h5566_7788;
    chk(rv == 0 && !ev, "R11 collision no read data", rv, 0);
    read_word("R11 collision write done");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule